// File: doc/BRIEF.md
# Segmented Ternary-Masked Content-Addressable Memory

This block holds a small table of wide words and finds, in a single clock, every stored word that equals a search key. Each word carries a two-bit state tag that decides which searches can see it. A run-time field splits every word into a searched upper part and an unsearched lower part, in steps of one segment. The lower part acts as plain storage that travels with the key. Two loadable mask registers can hide further bit positions from a search, and either of them can also protect bit positions during a write.

Searches come in two kinds. A plain search sees only words tagged Valid. A forced search names the tag it wants, and a forced search for Empty ignores the data entirely. The result of the last search (hit, more-than-one hit, and the lowest hitting index) is held until the next search. It can also be used as the target of a later write or read. The block also tracks the lowest Empty slot and raises a full flag when there is none.

Top module: `seg_cam`

## Requirements
- R1: After reset every tag is Empty (2'b11), so free_addr is 0 and full is 0, and match_flag, multi_flag, match_addr and rd_vld are all 0.
- R2: Commands are taken when cmd_vld is 1, with cmd_op 1=write, 2=read, 3=search, 4=forced search, 5=load mask 0, 6=load mask 1, 7=load address register. A read drives rd_vld high on the next cycle, with the stored word on rd_data and its tag on rd_tag.
- R3: cfg_split=n (n<4) removes the lowest 16*n bits of every word from searches, so 3'b001 searches only bits 63:16. Any value with the top bit set removes all bits, and every word with a suitable tag then hits.
- R4: cfg_msel selects the search mask: 2'b01 mask 0, 2'b10 mask 1, and 2'b00 or 2'b11 no mask. A mask bit of 1 excludes that bit position from the search.
- R5: A plain search (cmd_op 3) matches only words tagged Valid (2'b00). Skip is 2'b01 and Random is 2'b10.
- R6: A forced search (cmd_op 4) matches words whose tag equals cmd_tag. When cmd_tag is Empty, all data bits are ignored.
- R7: The lowest hitting index wins and appears on match_addr, and multi_flag rises when two or more words hit. With no hit, match_flag, multi_flag and match_addr are all 0.
- R8: free_addr is the lowest index tagged Empty, and full is 1 exactly when no word is Empty.
- R9: cmd_asrc selects the target of a write or read: 0 cmd_addr, 1 the address register, 2 free_addr, 3 match_addr. A source 2 access while full, or a source 3 access while match_flag is 0, is dropped.
- R10: A write stores cmd_tag. Under cmd_wmsel (same encoding as cfg_msel), data bits whose selected mask bit is 1 keep their old value.
- R11: match_flag, multi_flag and match_addr change only on the cycle after a search command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 64 | Write data, search key or mask/address load value |
| cmd_tag | input | 2 | Tag to write, or tag wanted by a forced search |
| cmd_addr | input | 4 | Direct address, or address register load value |
| cmd_asrc | input | 2 | Address source for write and read |
| cmd_wmsel | input | 2 | Write protection mask select |
| cfg_split | input | 3 | Searched/stored partition field |
| cfg_msel | input | 2 | Search mask select |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 64 | Read word |
| rd_tag | output | 2 | Tag of read word |
| match_flag | output | 1 | Last search hit |
| multi_flag | output | 1 | Last search hit more than once |
| match_addr | output | 4 | Lowest hitting index of last search |
| free_addr | output | 4 | Lowest Empty index |
| full | output | 1 | No Empty word left |

## Verification
The assertions assume that cmd_op carries meaning only while cmd_vld is high. They also assume that the configuration inputs stay steady while a search is issued. Commands start only after the internal reset has left its synchronizer. The stimulus changes cfg_split and cfg_msel only between commands and waits several cycles after releasing reset. It also reads only words it has written before, so the stored data is always defined when it is compared.

// File: rtl/seg_cam_pkg.sv
package seg_cam_pkg;
  typedef enum logic [1:0] {
    TAG_VALID  = 2'b00,
    TAG_SKIP   = 2'b01,
    TAG_RANDOM = 2'b10,
    TAG_EMPTY  = 2'b11
  } tag_e;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_CMP   = 3'd3,
    OP_FCMP  = 3'd4,
    OP_LDM0  = 3'd5,
    OP_LDM1  = 3'd6,
    OP_LDADR = 3'd7
  } op_e;

  localparam logic [1:0] SRC_DIRECT = 2'd0;
  localparam logic [1:0] SRC_AREG   = 2'd1;
  localparam logic [1:0] SRC_FREE   = 2'd2;
  localparam logic [1:0] SRC_MATCH  = 2'd3;
endpackage

// File: rtl/seg_cam_entry.sv
module seg_cam_entry #(
  parameter int W = 64
) (
  input  logic [W-1:0] ent_data,
  input  logic [1:0]   ent_tag,
  input  logic [W-1:0] key,
  input  logic [W-1:0] care,
  input  logic [1:0]   want_tag,
  output logic         hit
);
  logic tag_ok;
  logic data_ok;

  always_comb begin
    tag_ok  = (ent_tag == want_tag);
    data_ok = ~|((ent_data ^ key) & care);
    hit     = tag_ok & data_ok;
  end
endmodule

// File: rtl/seg_cam_prio.sv
module seg_cam_prio #(
  parameter int N  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [AW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = AW'(i);
    end
  end
endmodule

// File: rtl/seg_cam.sv
module seg_cam
  import seg_cam_pkg::*;
#(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  parameter int SEG   = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_vld,
  input  logic [2:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  input  logic [1:0]    cmd_tag,
  input  logic [AW-1:0] cmd_addr,
  input  logic [1:0]    cmd_asrc,
  input  logic [1:0]    cmd_wmsel,
  input  logic [2:0]    cfg_split,
  input  logic [1:0]    cfg_msel,
  output logic          rd_vld,
  output logic [W-1:0]  rd_data,
  output logic [1:0]    rd_tag,
  output logic          match_flag,
  output logic          multi_flag,
  output logic [AW-1:0] match_addr,
  output logic [AW-1:0] free_addr,
  output logic          full
);
  localparam int NSEG = W / SEG;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  // storage
  logic [DEPTH-1:0][W-1:0] data_q;
  logic [DEPTH-1:0][1:0]   tag_q, tag_d;
  logic [W-1:0]            mask0_q, mask0_d, mask1_q, mask1_d;
  logic [AW-1:0]           areg_q, areg_d;
  logic                    match_q, match_d, multi_q, multi_d;
  logic [AW-1:0]           maddr_q, maddr_d;
  logic                    rd_vld_q;
  logic [W-1:0]            rd_data_q;
  logic [1:0]              rd_tag_q;

  // command decode
  op_e  op;
  logic is_wr, is_rd, is_cmp, is_fcmp, cmp_go;
  assign op      = op_e'(cmd_op);
  assign is_wr   = cmd_vld && (op == OP_WRITE);
  assign is_rd   = cmd_vld && (op == OP_READ);
  assign is_cmp  = cmd_vld && (op == OP_CMP);
  assign is_fcmp = cmd_vld && (op == OP_FCMP);
  assign cmp_go  = is_cmp || is_fcmp;

  // partition: segment s is storage-only when cfg_split > s
  logic [W-1:0] ram_mask;
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign ram_mask[s*SEG +: SEG] = {SEG{int'(cfg_split) > s}};
  end

  // mask selection for search and write
  logic [W-1:0] srch_mask, wr_mask, care;
  logic [1:0]   want_tag;

  always_comb begin
    unique case (cfg_msel)
      2'b01:   srch_mask = mask0_q;
      2'b10:   srch_mask = mask1_q;
      default: srch_mask = '0;
    endcase
    unique case (cmd_wmsel)
      2'b01:   wr_mask = mask0_q;
      2'b10:   wr_mask = mask1_q;
      default: wr_mask = '0;
    endcase
    want_tag = is_fcmp ? cmd_tag : TAG_VALID;
    if (is_fcmp && (cmd_tag == TAG_EMPTY)) care = '0;
    else                                  care = ~(ram_mask | srch_mask);
  end

  // parallel compare and empty detection
  logic [DEPTH-1:0] hit, empty_vec;
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    seg_cam_entry #(.W(W)) u_ent (
      .ent_data (data_q[i]),
      .ent_tag  (tag_q[i]),
      .key      (cmd_data),
      .care     (care),
      .want_tag (want_tag),
      .hit      (hit[i])
    );
    assign empty_vec[i] = (tag_q[i] == TAG_EMPTY);
  end

  logic          hit_any, free_any;
  logic [AW-1:0] hit_idx, free_idx;

  seg_cam_prio #(.N(DEPTH), .AW(AW)) u_hit_pe (
    .vec (hit),
    .any (hit_any),
    .idx (hit_idx)
  );

  seg_cam_prio #(.N(DEPTH), .AW(AW)) u_free_pe (
    .vec (empty_vec),
    .any (free_any),
    .idx (free_idx)
  );

  // target address for write and read
  logic [AW-1:0] tgt;
  logic          tgt_ok, wr_go, rd_go;
  logic [W-1:0]  wr_word;

  always_comb begin
    unique case (cmd_asrc)
      SRC_DIRECT: begin tgt = cmd_addr; tgt_ok = 1'b1;     end
      SRC_AREG:   begin tgt = areg_q;   tgt_ok = 1'b1;     end
      SRC_FREE:   begin tgt = free_idx; tgt_ok = free_any; end
      default:    begin tgt = maddr_q;  tgt_ok = match_q;  end
    endcase
    wr_go   = is_wr && tgt_ok;
    rd_go   = is_rd && tgt_ok;
    wr_word = (data_q[tgt] & wr_mask) | (cmd_data & ~wr_mask);
  end

  // next state
  always_comb begin
    tag_d   = tag_q;
    mask0_d = mask0_q;
    mask1_d = mask1_q;
    areg_d  = areg_q;
    match_d = match_q;
    multi_d = multi_q;
    maddr_d = maddr_q;
    if (wr_go) tag_d[tgt] = cmd_tag;
    if (cmd_vld && (op == OP_LDM0))  mask0_d = cmd_data;
    if (cmd_vld && (op == OP_LDM1))  mask1_d = cmd_data;
    if (cmd_vld && (op == OP_LDADR)) areg_d  = cmd_addr;
    if (cmp_go) begin
      match_d = hit_any;
      multi_d = |(hit & (hit - DEPTH'(1)));
      maddr_d = hit_idx;
    end
  end

  // registers with reset
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tag_q    <= {DEPTH{TAG_EMPTY}};
      mask0_q  <= '0;
      mask1_q  <= '0;
      areg_q   <= '0;
      match_q  <= 1'b0;
      multi_q  <= 1'b0;
      maddr_q  <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      tag_q    <= tag_d;
      mask0_q  <= mask0_d;
      mask1_q  <= mask1_d;
      areg_q   <= areg_d;
      match_q  <= match_d;
      multi_q  <= multi_d;
      maddr_q  <= maddr_d;
      rd_vld_q <= rd_go;
    end
  end

  // data storage and read path, enable only
  always_ff @(posedge clk) begin
    if (wr_go) data_q[tgt] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_go) begin
      rd_data_q <= data_q[tgt];
      rd_tag_q  <= tag_q[tgt];
    end
  end

  assign rd_vld     = rd_vld_q;
  assign rd_data    = rd_data_q;
  assign rd_tag     = rd_tag_q;
  assign match_flag = match_q;
  assign multi_flag = multi_q;
  assign match_addr = maddr_q;
  assign free_addr  = free_idx;
  assign full       = ~free_any;
endmodule

// File: rtl/seg_cam_chk.sv
module seg_cam_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic                  clk,
  input logic                  rst_q,
  input logic                  cmd_vld,
  input logic [2:0]            cmd_op,
  input logic [1:0]            cmd_asrc,
  input logic                  rd_vld,
  input logic                  match_flag,
  input logic                  multi_flag,
  input logic [AW-1:0]         match_addr,
  input logic [AW-1:0]         free_addr,
  input logic                  full,
  input logic [DEPTH-1:0][1:0] tags
);
  logic srch;
  assign srch = cmd_vld && ((cmd_op == 3'd3) || (cmd_op == 3'd4));

  assert_multi_needs_match_R7: assert property (@(posedge clk) disable iff (!rst_q)
    multi_flag |-> match_flag);

  assert_miss_zero_addr_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !match_flag |-> (match_addr == '0));

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_q)
    !srch |=> ($stable(match_flag) && $stable(multi_flag) && $stable(match_addr)));

  assert_direct_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_vld && (cmd_op == 3'd2) && (cmd_asrc == 2'd0)) |=> rd_vld);

  assert_free_slot_empty_R8: assert property (@(posedge clk) disable iff (!rst_q)
    !full |-> (tags[free_addr] == 2'b11));

  for (genvar i = 0; i < DEPTH; i++) begin : g_low
    assert_nothing_empty_below_R8: assert property (@(posedge clk) disable iff (!rst_q)
      (full || (AW'(i) < free_addr)) |-> (tags[i] != 2'b11));
  end
endmodule

bind seg_cam seg_cam_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_q      (rst_q),
  .cmd_vld    (cmd_vld),
  .cmd_op     (cmd_op),
  .cmd_asrc   (cmd_asrc),
  .rd_vld     (rd_vld),
  .match_flag (match_flag),
  .multi_flag (multi_flag),
  .match_addr (match_addr),
  .free_addr  (free_addr),
  .full       (full),
  .tags       (tag_q)
);

// File: tb/seg_cam_tb_top.sv
module seg_cam_tb_top;
  localparam int AW = 4;
  localparam int N  = 16;

  logic          clk;
  logic          rst_n;
  logic          cmd_vld;
  logic [2:0]    cmd_op;
  logic [63:0]   cmd_data;
  logic [1:0]    cmd_tag;
  logic [AW-1:0] cmd_addr;
  logic [1:0]    cmd_asrc;
  logic [1:0]    cmd_wmsel;
  logic [2:0]    cfg_split;
  logic [1:0]    cfg_msel;
  logic          rd_vld;
  logic [63:0]   rd_data;
  logic [1:0]    rd_tag;
  logic          match_flag, multi_flag, full;
  logic [AW-1:0] match_addr, free_addr;

  seg_cam dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_tag(cmd_tag), .cmd_addr(cmd_addr),
    .cmd_asrc(cmd_asrc), .cmd_wmsel(cmd_wmsel), .cfg_split(cfg_split),
    .cfg_msel(cfg_msel), .rd_vld(rd_vld), .rd_data(rd_data), .rd_tag(rd_tag),
    .match_flag(match_flag), .multi_flag(multi_flag), .match_addr(match_addr),
    .free_addr(free_addr), .full(full)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [63:0] d;
    logic [1:0]  t;
    string       req;
  } rd_item_t;
  rd_item_t exp_q[$];

  logic [63:0] mdata [N];
  logic [1:0]  mtag  [N];
  logic [63:0] bm0, bm1;

  localparam logic [63:0] KA = 64'h1111_2222_3333_4444;
  localparam logic [63:0] KB = 64'h1111_2222_3333_5555;
  localparam logic [63:0] KC = 64'hCCCC_0000_CCCC_0000;
  localparam logic [63:0] KD = 64'hDDDD_1234_DDDD_5678;
  localparam logic [63:0] KE = 64'hEEEE_EEEE_0000_0001;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [63:0] d, input logic [1:0] t,
                       input logic [AW-1:0] a, input logic [1:0] s, input logic [1:0] wm);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = o; cmd_data = d; cmd_tag = t;
    cmd_addr = a; cmd_asrc = s; cmd_wmsel = wm;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_op = 3'd0;
  endtask

  // write; ea is the address the requirements say is hit, -1 when dropped
  task automatic wr(input logic [1:0] s, input logic [AW-1:0] a, input int ea,
                    input logic [63:0] d, input logic [1:0] t, input logic [1:0] wm);
    logic [63:0] pm;
    pm = (wm == 2'b01) ? bm0 : ((wm == 2'b10) ? bm1 : 64'd0);
    if (ea >= 0) begin
      mdata[ea] = (mdata[ea] & pm) | (d & ~pm);
      mtag[ea]  = t;
    end
    issue(3'd1, d, t, a, s, wm);
  endtask

  task automatic rd(input logic [1:0] s, input logic [AW-1:0] a, input int ea, input string req);
    rd_item_t it;
    it.d = mdata[ea]; it.t = mtag[ea]; it.req = req;
    exp_q.push_back(it);
    issue(3'd2, 64'd0, 2'd0, a, s, 2'd0);
  endtask

  task automatic cmp_res(input string req, input logic m, input logic mm, input logic [AW-1:0] ad);
    chk({req, " match_flag"}, {63'd0, match_flag}, {63'd0, m});
    chk({req, " multi_flag"}, {63'd0, multi_flag}, {63'd0, mm});
    chk({req, " match_addr"}, {60'd0, match_addr}, {60'd0, ad});
  endtask

  // monitor: pops expected read items as results appear
  always @(negedge clk) begin
    if (rst_n && rd_vld === 1'b1) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected read actual=%h expected=none", rd_data);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk({it.req, " rd_data"}, rd_data, it.d);
        chk({it.req, " rd_tag"}, {62'd0, rd_tag}, {62'd0, it.t});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cmd_vld = 0; cmd_op = 0; cmd_data = 0; cmd_tag = 0; cmd_addr = 0;
    cmd_asrc = 0; cmd_wmsel = 0; cfg_split = 3'd0; cfg_msel = 2'd0;
    bm0 = 64'd0; bm1 = 64'd0;
    for (int i = 0; i < N; i++) begin mdata[i] = 64'd0; mtag[i] = 2'b11; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 free_addr", {60'd0, free_addr}, 64'd0);
    chk("R1 full", {63'd0, full}, 64'd0);
    chk("R1 rd_vld", {63'd0, rd_vld}, 64'd0);
    cmp_res("R1", 1'b0, 1'b0, 4'd0);

    // R2 direct writes and reads
    wr(2'd0, 4'd0, 0, KA, 2'b00, 2'd0);
    wr(2'd0, 4'd1, 1, KB, 2'b00, 2'd0);
    wr(2'd0, 4'd2, 2, KA, 2'b01, 2'd0);
    rd(2'd0, 4'd0, 0, "R2 read0");
    rd(2'd0, 4'd1, 1, "R2 read1");
    rd(2'd0, 4'd2, 2, "R2 read2");
    chk("R8 free after three", {60'd0, free_addr}, 64'd3);

    // R5 plain search sees Valid only
    issue(3'd3, KA, 2'd0, 4'd0, 2'd0, 2'd0);
    cmp_res("R5 valid only", 1'b1, 1'b0, 4'd0);

    // R3 split 001 ignores low 16 bits
    cfg_split = 3'b001;
    issue(3'd3, KA, 2'd0, 4'd0, 2'd0, 2'd0);
    cmp_res("R3 split001", 1'b1, 1'b1, 4'd0);
    cfg_split = 3'b000;

    // R4 mask selection
    bm0 = 64'h0000_0000_0000_FFFF;
    issue(3'd5, bm0, 2'd0, 4'd0, 2'd0, 2'd0);
    issue(3'd6, bm1, 2'd0, 4'd0, 2'd0, 2'd0);
    cfg_msel = 2'b01;
    issue(3'd3, KA, 2'd0, 4'd0, 2'd0, 2'd0);
    cmp_res("R4 mask0", 1'b1, 1'b1, 4'd0);
    cfg_msel = 2'b10;
    issue(3'd3, KB, 2'd0, 4'd0, 2'd0, 2'd0);
    cmp_res("R4 mask1", 1'b1, 1'b0, 4'd1);
    cfg_msel = 2'b11;
    issue(3'd3, KA, 2'd0, 4'd0, 2'd0, 2'd0);
    cmp_res("R4 nomask", 1'b1, 1'b0, 4'd0);
    cfg_msel = 2'b00;

    // R6 forced searches
    issue(3'd4, KA, 2'b01, 4'd0, 2'd0, 2'd0);
    cmp_res("R6 skip", 1'b1, 1'b0, 4'd2);
    issue(3'd4, 64'hFFFF_0000_FFFF_0000, 2'b11, 4'd0, 2'd0, 2'd0);
    cmp_res("R6 empty ignores data", 1'b1, 1'b1, 4'd3);
    issue(3'd4, KA, 2'b10, 4'd0, 2'd0, 2'd0);
    cmp_res("R7 no hit", 1'b0, 1'b0, 4'd0);

    // R11 non-search commands leave result alone
    issue(3'd5, bm0, 2'd0, 4'd0, 2'd0, 2'd0);
    cmp_res("R11 hold", 1'b0, 1'b0, 4'd0);

    // R9 match-source write dropped with no hit
    wr(2'd3, 4'd0, -1, KC, 2'b11, 2'd0);
    chk("R9 dropped match write", {60'd0, free_addr}, 64'd3);

    // R9 match-source write after a hit
    issue(3'd4, KA, 2'b01, 4'd0, 2'd0, 2'd0);
    cmp_res("R6 skip again", 1'b1, 1'b0, 4'd2);
    wr(2'd3, 4'd0, 2, KC, 2'b00, 2'd0);
    rd(2'd0, 4'd2, 2, "R9 match write");
    rd(2'd3, 4'd0, 2, "R9 match read");

    // R9 address register source
    issue(3'd7, 64'd0, 2'd0, 4'd5, 2'd0, 2'd0);
    wr(2'd1, 4'd0, 5, KD, 2'b10, 2'd0);
    rd(2'd1, 4'd0, 5, "R9 areg read");
    chk("R8 free after areg", {60'd0, free_addr}, 64'd3);

    // R9 next-free source
    wr(2'd2, 4'd0, 3, KE, 2'b00, 2'd0);
    rd(2'd0, 4'd3, 3, "R9 free write");
    chk("R8 free advances", {60'd0, free_addr}, 64'd4);

    // R10 protected write
    wr(2'd0, 4'd0, 0, 64'd0, 2'b00, 2'b01);
    rd(2'd0, 4'd0, 0, "R10 masked write");

    // R8 fill to full
    for (int k = 0; k < N; k++) begin
      int lo;
      lo = -1;
      for (int j = N - 1; j >= 0; j--) if (mtag[j] == 2'b11) lo = j;
      if (lo >= 0) wr(2'd2, 4'd0, lo, 64'h5A5A_0000_0000_0000 | 64'(k), 2'b00, 2'd0);
    end
    chk("R8 full", {63'd0, full}, 64'd1);
    wr(2'd2, 4'd0, -1, KA, 2'b11, 2'd0);
    issue(3'd4, 64'd0, 2'b11, 4'd0, 2'd0, 2'd0);
    cmp_res("R9 full write dropped", 1'b0, 1'b0, 4'd0);
    issue(3'd2, 64'd0, 2'd0, 4'd0, 2'd2, 2'd0);
    chk("R9 full read dropped", {63'd0, rd_vld}, 64'd0);
    rd(2'd0, 4'd15, 15, "R8 last slot");

    // R3 all-storage split
    cfg_split = 3'b100;
    issue(3'd3, 64'h0123_4567_89AB_CDEF, 2'd0, 4'd0, 2'd0, 2'd0);
    cmp_res("R3 all storage", 1'b1, 1'b1, 4'd0);
    issue(3'd4, KA, 2'b10, 4'd0, 2'd0, 2'd0);
    cmp_res("R3 all storage random", 1'b1, 1'b0, 4'd5);
    cfg_split = 3'b000;

    repeat (3) @(negedge clk);
    chk("R2 all reads seen", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule